// File: doc/BRIEF.md
# Cascadable Vectored Interrupt Controller

This block arbitrates eight interrupt request lines under a fixed priority order and raises a single interrupt output toward whatever sits above it. A strap input chooses its role. Strapped as a master, it talks to the processor. Strapped as a slave, its interrupt output feeds one request line of a master. Several instances built this way form a two-level tree.

The processor answers an interrupt with three acknowledge pulses, and every instance in the tree sees all three. The master always answers the first pulse with the CALL opcode. If the winning master input has a slave behind it, the master also places that input's number on the 3-bit cascade lines, and the slave whose configured ID matches supplies the two address bytes. A request wired straight into a master input is handled by the master alone, which supplies all three bytes.

Every instance keeps its own settings, loaded through a small write port:
- a mask,
- a per-input slave-present map,
- a 3-bit ID,
- a 16-bit vector base.

It also keeps an in-service register. That register blocks requests of equal or lower priority until software issues an end-of-interrupt write.

Top module: `vic_node`

## Requirements
- R1: After a synchronous active-low reset these outputs are low: `irq_out`, `data_oe` and `cas_oe`. The mask resets to all ones, so every input is masked. The in-service register, the slave-present map, the ID and the base all reset to zero.
- R2: `irq_out` rises one clock after an unmasked request appears whose input number is below every in-service input number. A request whose mask bit is 1 never raises `irq_out`.
- R3: Priority is fixed. Input 0 is the highest and input 7 the lowest. When several requests are eligible, the lowest-numbered one wins the acknowledge.
- R4: A master whose winning input has a 0 in the slave-present map drives three bytes, each in the cycle after the matching acknowledge pulse: 0xCD, then bits 7:0 of base+4*n, then bits 15:8 of base+4*n. In this case `cas_oe` stays low.
- R5: A master whose winning input n has a 1 in the slave-present map drives 0xCD after pulse one. It raises `cas_oe` with `cas_out`=n from pulse one until pulse three, and it drives no data after pulses two and three.
- R6: A slave never raises `cas_oe` and never drives data after pulse one. At pulse two it compares `cas_in` with its ID. On a match it drives the low address byte after pulse two and the high byte after pulse three. On a mismatch it drives nothing.
- R7: The winner's in-service bit is set on the pulse where the device takes the acknowledge: pulse one in a master, pulse two in a matched slave. After that, requests of the same or lower priority no longer raise `irq_out`, but a higher-priority request still does.
- R8: Writing to address 7 clears only the highest-priority in-service bit.
- R9: The configuration writes take effect on the next clock. The register addresses are:
  - address 0: mask
  - address 1: ID (bits 2:0)
  - address 2: slave-present map
  - address 3: base bits 7:0
  - address 4: base bits 15:8

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| is_master | input | 1 | Role strap: 1 = master, 0 = slave |
| req | input | 8 | Request lines, bit 0 highest priority |
| irq_out | output | 1 | Interrupt toward the master or the processor |
| inta_pulse | input | 1 | One-cycle strobe per acknowledge pulse |
| cas_in | input | 3 | Cascade lines as seen on the bus |
| cas_out | output | 3 | Cascade value driven by a master |
| cas_oe | output | 1 | Cascade output enable (master only) |
| data_out | output | 8 | Acknowledge byte |
| data_oe | output | 1 | Data output enable, high while this device is selected |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register address |
| cfg_wdata | input | 8 | Configuration write data |

## Verification
The assertions check a fixed set of rules on every cycle:
- the cascade enable only ever rises in a master,
- a data enable always follows an acknowledge pulse,
- a slave stays off the bus after pulse one,
- at most one in-service bit appears per cycle,
- an end-of-interrupt write removes exactly one bit,
- the interrupt output is backed by an unmasked request.

Other behaviour only shows in the bench's two-device tree:
- the byte values and their ordering across master and slave,
- the carry of base+4*n into the high byte,
- the priority choice among competing inputs,
- a slave with a non-matching ID staying silent.

// File: rtl/vic_pkg.sv
// Package: shared constants and types for the cascadable interrupt controller.
// Assumes an 8-bit data bus and a 16-bit vector made of two data bytes.
package vic_pkg;

    localparam logic [7:0] CALL_OPCODE = 8'hCD;

    // Configuration register addresses
    localparam logic [2:0] REG_MASK = 3'd0;
    localparam logic [2:0] REG_ID   = 3'd1;
    localparam logic [2:0] REG_CMAP = 3'd2;
    localparam logic [2:0] REG_BLO  = 3'd3;
    localparam logic [2:0] REG_BHI  = 3'd4;
    localparam logic [2:0] REG_EOI  = 3'd7;

    // Position inside the three-pulse acknowledge sequence
    typedef enum logic [1:0] {
        ACK_P1 = 2'd0,
        ACK_P2 = 2'd1,
        ACK_P3 = 2'd2
    } ack_phase_t;

endpackage

// File: rtl/vic_prio.sv
// Module: vic_prio
// Fixed-priority resolver. Input 0 is the highest priority.
// A request is eligible when it is unmasked and ranks strictly above every
// in-service bit. Purely combinational.
module vic_prio #(
    parameter int N_IN = 8,
    parameter int ID_W = $clog2(N_IN)
) (
    input  logic [N_IN-1:0] req,
    input  logic [N_IN-1:0] mask,
    input  logic [N_IN-1:0] isr,
    output logic            win_valid,
    output logic [ID_W-1:0] win_idx
);

    logic [N_IN-1:0] isr_top;
    logic [N_IN-1:0] window;
    logic [N_IN-1:0] cand;

    // Build the priority window: only bits below the highest-priority
    // in-service bit are open (all bits are open when nothing is in service).
    always_comb begin
        isr_top = isr & (~isr + N_IN'(1));
        window  = isr_top - N_IN'(1);
        cand    = req & ~mask & window;
    end

    // Encode the lowest-numbered eligible request.
    always_comb begin
        win_valid = |cand;
        win_idx   = '0;
        for (int i = N_IN - 1; i >= 0; i--) begin
            if (cand[i]) win_idx = ID_W'(i);
        end
    end

endmodule

// File: rtl/vic_regs.sv
// Module: vic_regs
// Holds the configuration registers and the in-service register.
// Assumes the data width equals N_IN so that the mask and map take whole bytes.
// The end-of-interrupt clear applies before the acknowledge set in the same cycle.
module vic_regs
    import vic_pkg::*;
#(
    parameter int N_IN  = 8,
    parameter int ID_W  = $clog2(N_IN),
    parameter int DW    = 8,
    parameter int VEC_W = 2 * DW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [2:0]       cfg_addr,
    input  logic [DW-1:0]    cfg_wdata,
    input  logic             isr_set,
    input  logic [ID_W-1:0]  isr_set_idx,
    output logic [N_IN-1:0]  mask,
    output logic [N_IN-1:0]  cmap,
    output logic [ID_W-1:0]  my_id,
    output logic [VEC_W-1:0] base,
    output logic [N_IN-1:0]  isr
);

    logic            eoi;
    logic [N_IN-1:0] eoi_clr;
    logic [N_IN-1:0] set_vec;

    // Decode the end-of-interrupt command and the acknowledge set vector.
    always_comb begin
        eoi     = cfg_we && (cfg_addr == REG_EOI);
        eoi_clr = eoi ? (isr & (~isr + N_IN'(1))) : '0;
        set_vec = isr_set ? (N_IN'(1) << isr_set_idx) : '0;
    end

    // Configuration register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask  <= '1;
            cmap  <= '0;
            my_id <= '0;
            base  <= '0;
        end else if (cfg_we) begin
            case (cfg_addr)
                REG_MASK: mask  <= cfg_wdata[N_IN-1:0];
                REG_ID:   my_id <= cfg_wdata[ID_W-1:0];
                REG_CMAP: cmap  <= cfg_wdata[N_IN-1:0];
                REG_BLO:  base[DW-1:0]       <= cfg_wdata;
                REG_BHI:  base[VEC_W-1:DW]   <= cfg_wdata;
                default:  ;
            endcase
        end
    end

    // In-service register: clear the highest-priority bit on EOI, then set the winner.
    always_ff @(posedge clk) begin
        if (!rst_n) isr <= '0;
        else        isr <= (isr & ~eoi_clr) | set_vec;
    end

endmodule

// File: rtl/vic_ack.sv
// Module: vic_ack
// Sequences the three acknowledge pulses. A master sends the opcode and,
// for cascaded inputs, the input number on the cascade lines. Otherwise the
// master sends the two vector bytes itself. A slave claims pulses two and
// three when cas_in matches its ID. Each byte is driven in the cycle after its pulse.
module vic_ack
    import vic_pkg::*;
#(
    parameter int N_IN    = 8,
    parameter int ID_W    = $clog2(N_IN),
    parameter int DW      = 8,
    parameter int VEC_W   = 2 * DW,
    parameter int STEP_SH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             is_master,
    input  logic             inta_pulse,
    input  logic [ID_W-1:0]  cas_in,
    input  logic [ID_W-1:0]  my_id,
    input  logic [N_IN-1:0]  cmap,
    input  logic [VEC_W-1:0] base,
    input  logic             win_valid,
    input  logic [ID_W-1:0]  win_idx,
    output logic [DW-1:0]    data_out,
    output logic             data_oe,
    output logic [ID_W-1:0]  cas_out,
    output logic             cas_oe,
    output logic             isr_set,
    output logic [ID_W-1:0]  isr_set_idx,
    output logic [1:0]       phase_o
);

    localparam logic [ID_W-1:0] IDX_DEFAULT = ID_W'(N_IN - 1);

    ack_phase_t       phase;
    logic [ID_W-1:0]  held_idx;
    logic             via_slave;
    logic             slave_sel;
    logic [ID_W-1:0]  pick_idx;
    logic             pick_cas;
    logic             id_match;
    logic [VEC_W-1:0] vec_pick;
    logic [VEC_W-1:0] vec_held;

    // Current choice and the vector addresses for the live and the held winner.
    always_comb begin
        pick_idx = win_valid ? win_idx : IDX_DEFAULT;
        pick_cas = cmap[pick_idx];
        id_match = (cas_in == my_id);
        vec_pick = base + (VEC_W'(pick_idx) << STEP_SH);
        vec_held = base + (VEC_W'(held_idx) << STEP_SH);
        phase_o  = phase;
    end

    // Tell the in-service register when this device takes the acknowledge.
    always_comb begin
        isr_set     = inta_pulse && win_valid &&
                      ((is_master && phase == ACK_P1) ||
                       (!is_master && phase == ACK_P2 && id_match));
        isr_set_idx = win_idx;
    end

    // Advance the pulse counter and drive the data and cascade outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= ACK_P1;
            held_idx  <= '0;
            via_slave <= 1'b0;
            slave_sel <= 1'b0;
            data_out  <= '0;
            data_oe   <= 1'b0;
            cas_out   <= '0;
            cas_oe    <= 1'b0;
        end else begin
            data_oe <= 1'b0;
            if (inta_pulse) begin
                case (phase)
                    ACK_P1: begin
                        phase <= ACK_P2;
                        if (is_master) begin
                            held_idx  <= pick_idx;
                            via_slave <= pick_cas;
                            data_out  <= CALL_OPCODE;
                            data_oe   <= 1'b1;
                            if (pick_cas) begin
                                cas_out <= pick_idx;
                                cas_oe  <= 1'b1;
                            end
                        end
                    end
                    ACK_P2: begin
                        phase <= ACK_P3;
                        if (is_master) begin
                            if (!via_slave) begin
                                data_out <= vec_held[DW-1:0];
                                data_oe  <= 1'b1;
                            end
                        end else if (id_match) begin
                            slave_sel <= 1'b1;
                            held_idx  <= pick_idx;
                            data_out  <= vec_pick[DW-1:0];
                            data_oe   <= 1'b1;
                        end
                    end
                    default: begin
                        phase <= ACK_P1;
                        if ((is_master && !via_slave) || (!is_master && slave_sel)) begin
                            data_out <= vec_held[VEC_W-1:DW];
                            data_oe  <= 1'b1;
                        end
                        cas_oe    <= 1'b0;
                        slave_sel <= 1'b0;
                        via_slave <= 1'b0;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/vic_node.sv
// Module: vic_node (top)
// One node of a two-level interrupt tree: a priority resolver, the registers
// and the acknowledge sequencer. The role comes from the is_master strap.
// Assumes the surrounding bus resolves cas_in from the master's cas_out/cas_oe.
module vic_node
    import vic_pkg::*;
#(
    parameter int N_IN    = 8,
    parameter int DW      = 8,
    parameter int STEP_SH = 2,
    localparam int ID_W   = $clog2(N_IN),
    localparam int VEC_W  = 2 * DW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            is_master,
    input  logic [N_IN-1:0] req,
    output logic            irq_out,
    input  logic            inta_pulse,
    input  logic [ID_W-1:0] cas_in,
    output logic [ID_W-1:0] cas_out,
    output logic            cas_oe,
    output logic [DW-1:0]   data_out,
    output logic            data_oe,
    input  logic            cfg_we,
    input  logic [2:0]      cfg_addr,
    input  logic [DW-1:0]   cfg_wdata
);

    logic [N_IN-1:0]  mask;
    logic [N_IN-1:0]  cmap;
    logic [ID_W-1:0]  my_id;
    logic [VEC_W-1:0] base;
    logic [N_IN-1:0]  isr;
    logic             win_valid;
    logic [ID_W-1:0]  win_idx;
    logic             isr_set;
    logic [ID_W-1:0]  isr_set_idx;
    logic [1:0]       ack_phase;

    vic_prio #(.N_IN(N_IN), .ID_W(ID_W)) u_prio (
        .req       (req),
        .mask      (mask),
        .isr       (isr),
        .win_valid (win_valid),
        .win_idx   (win_idx)
    );

    vic_regs #(.N_IN(N_IN), .ID_W(ID_W), .DW(DW), .VEC_W(VEC_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_addr    (cfg_addr),
        .cfg_wdata   (cfg_wdata),
        .isr_set     (isr_set),
        .isr_set_idx (isr_set_idx),
        .mask        (mask),
        .cmap        (cmap),
        .my_id       (my_id),
        .base        (base),
        .isr         (isr)
    );

    vic_ack #(.N_IN(N_IN), .ID_W(ID_W), .DW(DW), .VEC_W(VEC_W), .STEP_SH(STEP_SH)) u_ack (
        .clk         (clk),
        .rst_n       (rst_n),
        .is_master   (is_master),
        .inta_pulse  (inta_pulse),
        .cas_in      (cas_in),
        .my_id       (my_id),
        .cmap        (cmap),
        .base        (base),
        .win_valid   (win_valid),
        .win_idx     (win_idx),
        .data_out    (data_out),
        .data_oe     (data_oe),
        .cas_out     (cas_out),
        .cas_oe      (cas_oe),
        .isr_set     (isr_set),
        .isr_set_idx (isr_set_idx),
        .phase_o     (ack_phase)
    );

    // Register the interrupt output from the resolver's decision.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_out <= 1'b0;
        else        irq_out <= win_valid;
    end

endmodule

// File: rtl/vic_node_chk.sv
// Module: vic_node_chk
// Protocol checker bound into every vic_node instance. It observes the ports
// and the in-service and phase state.
module vic_node_chk #(
    parameter int N_IN = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            is_master,
    input logic            inta_pulse,
    input logic [N_IN-1:0] req,
    input logic [N_IN-1:0] mask,
    input logic [N_IN-1:0] isr,
    input logic            irq_out,
    input logic            data_oe,
    input logic            cas_oe,
    input logic [1:0]      ack_phase,
    input logic            cfg_we,
    input logic [2:0]      cfg_addr
);

    // R1: reset leaves every output enable and the interrupt low
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!irq_out && !data_oe && !cas_oe));

    // R2: the interrupt output is backed by an unmasked request one cycle earlier
    a_r2_irq_backed: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> $past(|(req & ~mask)));

    // R4: the data enable only follows an acknowledge pulse
    a_r4_oe_after_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> $past(inta_pulse));

    // R5: only a master drives the cascade lines
    a_r5_cas_master_only: assert property (@(posedge clk) disable iff (!rst_n)
        cas_oe |-> is_master);

    // R6: a slave stays off the data bus after the first pulse
    a_r6_slave_silent_p1: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_master && inta_pulse && ack_phase == 2'd0) |=> !data_oe);

    // R7: at most one in-service bit is added per cycle
    a_r7_one_new_isr: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(isr & ~$past(isr)));

    // R8: an end-of-interrupt write with no acknowledge removes exactly one bit
    a_r8_eoi_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == 3'd7 && !inta_pulse && isr != '0) |=>
        ($countones(isr) + 1 == $countones($past(isr))));

endmodule

bind vic_node vic_node_chk #(.N_IN(N_IN)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .is_master  (is_master),
    .inta_pulse (inta_pulse),
    .req        (req),
    .mask       (mask),
    .isr        (isr),
    .irq_out    (irq_out),
    .data_oe    (data_oe),
    .cas_oe     (cas_oe),
    .ack_phase  (ack_phase),
    .cfg_we     (cfg_we),
    .cfg_addr   (cfg_addr)
);

// File: tb/vic_node_tb.sv
// Bench: a master (u_dut) with one slave behind input 3.
// A scoreboard queue holds the expected acknowledge bytes together with the
// device expected to drive each one.
module vic_node_tb;

    typedef struct {
        logic [7:0] val;
        bit         from_slave;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] m_ext = '0;
    logic [7:0] s_req = '0;
    logic       inta = 1'b0;
    logic       m_we = 1'b0, s_we = 1'b0;
    logic [2:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;

    logic       m_irq, s_irq, m_cas_oe, s_cas_oe, m_doe, s_doe;
    logic [2:0] m_cas, s_cas, cas_bus;
    logic [7:0] m_data, s_data, m_req;

    int   n_checks = 0;
    int   n_fail = 0;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    assign m_req   = m_ext | {4'b0, s_irq, 3'b0};
    assign cas_bus = m_cas_oe ? m_cas : 3'b000;

    vic_node u_dut (
        .clk(clk), .rst_n(rst_n), .is_master(1'b1), .req(m_req), .irq_out(m_irq),
        .inta_pulse(inta), .cas_in(3'b000), .cas_out(m_cas), .cas_oe(m_cas_oe),
        .data_out(m_data), .data_oe(m_doe), .cfg_we(m_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata)
    );

    vic_node u_slv (
        .clk(clk), .rst_n(rst_n), .is_master(1'b0), .req(s_req), .irq_out(s_irq),
        .inta_pulse(inta), .cas_in(cas_bus), .cas_out(s_cas), .cas_oe(s_cas_oe),
        .data_out(s_data), .data_oe(s_doe), .cfg_we(s_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input bit to_slave, input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_addr = a; cfg_wdata = d;
        if (to_slave) s_we = 1'b1; else m_we = 1'b1;
        @(negedge clk);
        m_we = 1'b0; s_we = 1'b0;
    endtask

    task automatic pulse();
        @(negedge clk) inta = 1'b1;
        @(negedge clk) inta = 1'b0;
        @(negedge clk);
    endtask

    task automatic expect_byte(input logic [7:0] v, input bit sl, input string tag);
        exp_t e;
        e.val = v; e.from_slave = sl; e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: compare every driven byte against the head of the scoreboard.
    always @(negedge clk) begin
        if (rst_n && (m_doe || s_doe)) begin
            if (m_doe && s_doe) begin
                check(1'b0, "R6 bus contention", 2, 1);
            end else if (sb.size() == 0) begin
                check(1'b0, "R6 unexpected drive", s_doe ? 1 : 0, -1);
            end else begin
                exp_t e;
                logic [7:0] got;
                e = sb.pop_front();
                got = s_doe ? s_data : m_data;
                check(s_doe == e.from_slave, {e.tag, " source"}, int'(s_doe), int'(e.from_slave));
                check(got == e.val, e.tag, got, e.val);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reaches the summary.
    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        wait_cyc(4);
        // R1: the reset state
        check(!m_irq && !m_doe && !m_cas_oe && !s_irq && !s_doe, "R1 outputs in reset", m_irq, 0);
        rst_n = 1'b1;
        m_ext = 8'h20;
        wait_cyc(3);
        check(m_irq == 1'b0, "R1 mask resets to all ones", m_irq, 0);

        // R9: program both devices through the register map
        wr(0, 3'd0, 8'h00);
        wr(0, 3'd2, 8'h08);
        wr(0, 3'd3, 8'hFC);
        wr(0, 3'd4, 8'h12);
        wr(1, 3'd0, 8'h00);
        wr(1, 3'd1, 8'h03);
        wr(1, 3'd3, 8'h00);
        wr(1, 3'd4, 8'h40);
        m_ext = 8'h60;
        wait_cyc(2);
        check(m_irq == 1'b1, "R2 unmasked request raises irq", m_irq, 1);

        // R3/R4/R9: inputs 5 and 6 compete; input 5 wins; 0x12FC+20 carries into the high byte
        expect_byte(8'hCD, 0, "R4 opcode");
        expect_byte(8'h10, 0, "R9 R4 low byte");
        expect_byte(8'h13, 0, "R3 R4 high byte");
        pulse();
        check(m_cas_oe == 1'b0, "R4 no cascade for direct input", m_cas_oe, 0);
        pulse();
        pulse();
        wait_cyc(2);
        check(m_irq == 1'b0, "R7 same and lower priority blocked", m_irq, 0);

        // R7: a higher-priority request still gets through
        m_ext = 8'h64;
        wait_cyc(2);
        check(m_irq == 1'b1, "R7 higher priority passes", m_irq, 1);
        expect_byte(8'hCD, 0, "R3 opcode");
        expect_byte(8'h04, 0, "R3 low byte input 2");
        expect_byte(8'h13, 0, "R3 high byte input 2");
        pulse(); pulse(); pulse();
        m_ext = 8'h60;
        wait_cyc(2);
        check(m_irq == 1'b0, "R7 inputs 2 and 5 in service", m_irq, 0);

        // R8: the first EOI clears input 2 only, so input 4 passes and input 6 stays blocked
        wr(0, 3'd7, 8'h00);
        wait_cyc(2);
        check(m_irq == 1'b0, "R8 input 5 still in service", m_irq, 0);
        m_ext = 8'h70;
        wait_cyc(2);
        check(m_irq == 1'b1, "R8 input 4 above remaining service", m_irq, 1);
        m_ext = 8'h60;
        wr(0, 3'd7, 8'h00);
        wait_cyc(2);
        check(m_irq == 1'b1, "R8 second EOI reopens input 5", m_irq, 1);
        m_ext = 8'h00;
        wait_cyc(2);

        // R2: a masked request is ignored
        wr(0, 3'd0, 8'h02);
        m_ext = 8'h02;
        wait_cyc(3);
        check(m_irq == 1'b0, "R2 masked request ignored", m_irq, 0);
        wr(0, 3'd0, 8'h00);
        wait_cyc(2);
        check(m_irq == 1'b1, "R2 unmask raises irq", m_irq, 1);
        m_ext = 8'h00;
        wait_cyc(2);

        // R5/R6: a cascaded request; slave ID 3 on master input 3
        s_req = 8'h02;
        wait_cyc(3);
        check(s_irq == 1'b1, "R2 slave irq", s_irq, 1);
        check(m_irq == 1'b1, "R5 master sees slave", m_irq, 1);
        expect_byte(8'hCD, 0, "R5 opcode from master");
        expect_byte(8'h04, 1, "R6 slave low byte");
        expect_byte(8'h40, 1, "R6 slave high byte");
        pulse();
        check(m_cas_oe && m_cas == 3'd3, "R5 cascade lines carry 3", m_cas, 3);
        check(s_cas_oe == 1'b0, "R6 slave never drives cascade", s_cas_oe, 0);
        pulse();
        check(m_cas_oe == 1'b1, "R5 cascade held through pulse two", m_cas_oe, 1);
        pulse();
        check(m_cas_oe == 1'b0, "R5 cascade released after pulse three", m_cas_oe, 0);
        wait_cyc(2);
        check(s_irq == 1'b0, "R7 slave in service", s_irq, 0);

        // R6: a slave with a non-matching ID stays silent
        wr(0, 3'd7, 8'h00);
        wr(1, 3'd7, 8'h00);
        wr(1, 3'd1, 8'h05);
        wait_cyc(3);
        check(s_irq == 1'b1, "R6 slave request pending", s_irq, 1);
        expect_byte(8'hCD, 0, "R5 opcode only");
        pulse(); pulse(); pulse();
        wait_cyc(2);
        check(s_irq == 1'b1, "R6 mismatched slave keeps request", s_irq, 1);
        check(sb.size() == 0, "R6 scoreboard drained", sb.size(), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule